// File: doc/BRIEF.md
# Quarter-Period Delay Single-Phase PLL

This block tracks the phase angle and frequency of one sampled grid voltage. The quadrature partner of the input is built in the simplest possible way: the input is delayed by one quarter of the nominal grid period. The input and its lagged copy are projected onto a frame that rotates with the estimated angle. The projection gives a quadrature error and a direct (amplitude) component.

A proportional-integral filter drives the quadrature error to zero. Its output is added to the nominal per-sample phase step, and a phase accumulator sums that step once per sample to form the angle. Because the lag is fixed in samples, the quadrature partner is exact only at the nominal grid frequency. Away from it, the loop still tracks frequency, but it carries a phase offset and a ripple at twice the grid frequency.

A lock flag reports that the error has stayed small for a programmable run of samples. Sine and cosine come from an internal quarter-wave table that is computed at elaboration.

Top module: `quad_delay_pll`

## Requirements
- R1: After reset, `angle_o` is 0, `step_o` equals the nominal step NOM_STEP (21474836, i.e. 50 Hz at 10 kHz for a 32-bit turn), `vd_o` is 0 and `locked_o` is 0. The lag line and the integral are cleared, so a zero input after reset keeps `step_o` at exactly NOM_STEP.
- R2: While `smp_valid` is low, `angle_o`, `step_o`, `vd_o` and `locked_o` do not change.
- R3: On each sample, `angle_o` advances by the new `step_o`, modulo 2^32. With an all-zero input the error is zero, so after n samples `angle_o` equals n·NOM_STEP mod 2^32.
- R4: The lagged signal is the input delayed by QDELAY = 50 samples. The error is v·cos(θ) + v_lag·sin(θ), where θ is the angle before the sample. With a 50 Hz tone the average step settles within 0.1 Hz of nominal, `vd_o` is within 2 % of the tone amplitude, and `locked_o` is 1.
- R5: For a tone between 45 Hz and 55 Hz, the average step over the last 1000 samples is within 0.3 Hz of the tone frequency. A frequency f maps to the step round(f/10000·2^32).
- R6: `step_o` always stays within STEP_MIN = 17179869 (40 Hz) and STEP_MAX = 25769803 (60 Hz), including for 30 Hz and 70 Hz inputs.
- R7: `locked_o` rises after exactly LOCK_LEN (400) consecutive samples with |error| < LOCK_THR (2^24). It falls after the first sample whose |error| reaches LOCK_THR.
- R8: On each sample, `vd_o` is loaded with (v·sin(θ) − v_lag·cos(θ)) >>> 15, an arithmetic shift, using the pre-sample θ. The trigonometric values use table entries e(i) = round(32767·sin((i+0.5)·π/2048)), i = 0..1023. The table is addressed by angle bits [29:20] and quadrant bits [31:30]: quadrants 1 and 3 read e(1023−i), quadrants 2 and 3 negate the entry, and cosine uses quadrant+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new input sample |
| smp_in | input | 16 | Signed grid voltage sample |
| angle_o | output | 32 | Estimated angle, one full turn = 2^32 |
| step_o | output | 32 | Estimated frequency as phase step per sample |
| vd_o | output | 18 | Signed direct component (amplitude estimate) |
| locked_o | output | 1 | Error has stayed below threshold for LOCK_LEN samples |

## Verification
The properties assume that `smp_in` is stable while `smp_valid` is high, and that reset is held for at least one clock before the first sample. They also assume the input amplitude leaves headroom in the 16-bit word; the stimulus keeps tones between 8000 and 20000 counts. Random tones are drawn only from 46 Hz to 54 Hz, where the fixed lag still lets the loop converge within the 3000-sample run. The 30 Hz and 70 Hz cases are used only to probe the frequency clamp, never the tracking accuracy. Exact-value checks (angle ramp, lock count, the single-sample direct component) are made from a zero-input state in which the angle is known without modelling the loop.

// File: rtl/qdp_pkg.sv
package qdp_pkg;

   // Rounded quarter-wave sine entry, evaluated at elaboration only
   function automatic int trig_entry(input int idx, input int abits, input int amp);
      real arg;
      arg = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(1 << abits));
      return $rtoi(real'(amp) * $sin(arg) + 0.5);
   endfunction

endpackage

// File: rtl/qdp_delay.sv
module qdp_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout
);

   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("qdp_delay: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_line
         logic signed [W-1:0] pipe [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
            end else if (en) begin
               pipe[0] <= din;
               for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
         end

         assign dout = pipe[DEPTH-1];

         // R4
         head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> pipe[0] == $past(din));
      end
   endgenerate

endmodule

// File: rtl/qdp_trig.sv
module qdp_trig #(
   parameter int LUT_ABITS = 10,
   parameter int TRIG_W    = 16
) (
   input  logic [LUT_ABITS+1:0]       phase,
   output logic signed [TRIG_W-1:0]   sin_o,
   output logic signed [TRIG_W-1:0]   cos_o
);

   localparam int N   = 1 << LUT_ABITS;
   localparam int AMP = (1 << (TRIG_W - 1)) - 1;

   logic [TRIG_W-1:0] tab [N];

   generate
      if (TRIG_W < 4 || LUT_ABITS < 2) begin : g_bad_size
         $error("qdp_trig: table too small");
      end
      for (genvar i = 0; i < N; i++) begin : g_tab
         localparam int VAL = qdp_pkg::trig_entry(i, LUT_ABITS, AMP);
         assign tab[i] = TRIG_W'(VAL);
      end
   endgenerate

   logic [1:0]           quad_s, quad_c;
   logic [LUT_ABITS-1:0] idx;
   logic [TRIG_W-1:0]    mag_s, mag_c;

   assign quad_s = phase[LUT_ABITS+1 -: 2];
   assign quad_c = quad_s + 2'd1;
   assign idx    = phase[LUT_ABITS-1:0];

   always_comb begin
      mag_s = tab[quad_s[0] ? ~idx : idx];
      mag_c = tab[quad_c[0] ? ~idx : idx];
      sin_o = quad_s[1] ? -$signed(mag_s) : $signed(mag_s);
      cos_o = quad_c[1] ? -$signed(mag_c) : $signed(mag_c);
   end

endmodule

// File: rtl/qdp_loop_filter.sv
module qdp_loop_filter #(
   parameter int ERR_W    = 33,
   parameter int ACC_W    = 35,
   parameter int PHASE_W  = 32,
   parameter int NOM_STEP = 21474836,
   parameter int STEP_MIN = 17179869,
   parameter int STEP_MAX = 25769803,
   parameter int KP_SHIFT = 6,
   parameter int KI_SHIFT = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [ERR_W-1:0] err,
   output logic [PHASE_W-1:0]      step_nxt,
   output logic [PHASE_W-1:0]      step_q
);

   localparam logic signed [ACC_W-1:0] NOM_S = ACC_W'(NOM_STEP);
   localparam logic signed [ACC_W-1:0] MIN_S = ACC_W'(STEP_MIN);
   localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'(STEP_MAX);
   localparam logic signed [ACC_W-1:0] IMIN  = MIN_S - NOM_S;
   localparam logic signed [ACC_W-1:0] IMAX  = MAX_S - NOM_S;
   localparam logic [PHASE_W-1:0]      MIN_U = PHASE_W'(STEP_MIN);
   localparam logic [PHASE_W-1:0]      MAX_U = PHASE_W'(STEP_MAX);

   generate
      if (ACC_W <= ERR_W || ACC_W <= PHASE_W) begin : g_bad_acc
         $error("qdp_loop_filter: accumulator narrower than its operands");
      end
      if (STEP_MIN > NOM_STEP || STEP_MAX < NOM_STEP) begin : g_bad_range
         $error("qdp_loop_filter: nominal step outside clamp range");
      end
   endgenerate

   logic signed [ACC_W-1:0] err_x, p_term, i_inc, i_sum, i_nxt, raw, step_c;
   logic signed [ACC_W-1:0] integ_q;

   always_comb begin
      err_x  = ACC_W'(err);
      p_term = err_x >>> KP_SHIFT;
      i_inc  = err_x >>> KI_SHIFT;
      i_sum  = integ_q + i_inc;
      if (i_sum > IMAX)      i_nxt = IMAX;
      else if (i_sum < IMIN) i_nxt = IMIN;
      else                   i_nxt = i_sum;
      raw = NOM_S + p_term + i_nxt;
      if (raw > MAX_S)       step_c = MAX_S;
      else if (raw < MIN_S)  step_c = MIN_S;
      else                   step_c = raw;
   end

   assign step_nxt = PHASE_W'(step_c);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ_q <= '0;
         step_q  <= PHASE_W'(NOM_STEP);
      end else if (en) begin
         integ_q <= i_nxt;
         step_q  <= step_nxt;
      end
   end

   // R6
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_q >= MIN_U && step_q <= MAX_U);

   // R6
   integ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      integ_q >= IMIN && integ_q <= IMAX);

endmodule

// File: rtl/quad_delay_pll.sv
module quad_delay_pll #(
   parameter int SAMPLE_W  = 16,
   parameter int PHASE_W   = 32,
   parameter int TRIG_W    = 16,
   parameter int LUT_ABITS = 10,
   parameter int QDELAY    = 50,
   parameter int NOM_STEP  = 21474836,
   parameter int STEP_MIN  = 17179869,
   parameter int STEP_MAX  = 25769803,
   parameter int KP_SHIFT  = 6,
   parameter int KI_SHIFT  = 13,
   parameter int LOCK_THR  = 1 << 24,
   parameter int LOCK_LEN  = 400
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         smp_valid,
   input  logic signed [SAMPLE_W-1:0]   smp_in,
   output logic [PHASE_W-1:0]           angle_o,
   output logic [PHASE_W-1:0]           step_o,
   output logic signed [SAMPLE_W+1:0]   vd_o,
   output logic                         locked_o
);

   localparam int PROD_W = SAMPLE_W + TRIG_W;
   localparam int ERR_W  = PROD_W + 1;
   localparam int ACC_W  = ((ERR_W > PHASE_W) ? ERR_W : PHASE_W) + 2;
   localparam int VD_W   = SAMPLE_W + 2;
   localparam int CNT_W  = $clog2(LOCK_LEN + 1);

   generate
      if (PHASE_W < LUT_ABITS + 2) begin : g_bad_phase
         $error("quad_delay_pll: phase word narrower than table address");
      end
      if (LOCK_LEN < 1) begin : g_bad_lock
         $error("quad_delay_pll: LOCK_LEN must be at least 1");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] v_lag;
   logic signed [TRIG_W-1:0]   sin_v, cos_v;
   logic signed [PROD_W-1:0]   p_vc, p_ls, p_vs, p_lc;
   logic signed [ERR_W-1:0]    vq, vd_full;
   logic [ERR_W-1:0]           vq_mag;
   logic                       err_small;
   logic [PHASE_W-1:0]         angle_q, step_nxt;
   logic signed [VD_W-1:0]     vd_q;
   logic [CNT_W-1:0]           run_cnt;

   qdp_delay #(.W(SAMPLE_W), .DEPTH(QDELAY)) u_lag (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (smp_valid),
      .din  (smp_in),
      .dout (v_lag)
   );

   qdp_trig #(.LUT_ABITS(LUT_ABITS), .TRIG_W(TRIG_W)) u_trig (
      .phase(angle_q[PHASE_W-1 -: LUT_ABITS+2]),
      .sin_o(sin_v),
      .cos_o(cos_v)
   );

   assign p_vc    = smp_in * cos_v;
   assign p_ls    = v_lag  * sin_v;
   assign p_vs    = smp_in * sin_v;
   assign p_lc    = v_lag  * cos_v;
   assign vq      = ERR_W'(p_vc) + ERR_W'(p_ls);
   assign vd_full = ERR_W'(p_vs) - ERR_W'(p_lc);
   assign vq_mag  = vq[ERR_W-1] ? ERR_W'(-vq) : ERR_W'(vq);
   assign err_small = vq_mag < ERR_W'(LOCK_THR);

   qdp_loop_filter #(
      .ERR_W   (ERR_W),
      .ACC_W   (ACC_W),
      .PHASE_W (PHASE_W),
      .NOM_STEP(NOM_STEP),
      .STEP_MIN(STEP_MIN),
      .STEP_MAX(STEP_MAX),
      .KP_SHIFT(KP_SHIFT),
      .KI_SHIFT(KI_SHIFT)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (smp_valid),
      .err     (vq),
      .step_nxt(step_nxt),
      .step_q  (step_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         angle_q <= '0;
         vd_q    <= '0;
         run_cnt <= '0;
      end else if (smp_valid) begin
         angle_q <= angle_q + step_nxt;
         vd_q    <= VD_W'(vd_full >>> (TRIG_W - 1));
         if (!err_small)                          run_cnt <= '0;
         else if (run_cnt != CNT_W'(LOCK_LEN))    run_cnt <= run_cnt + 1'b1;
      end
   end

   assign angle_o  = angle_q;
   assign vd_o     = vd_q;
   assign locked_o = (run_cnt == CNT_W'(LOCK_LEN));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(angle_o) && $stable(step_o) && $stable(vd_o) && $stable(locked_o));

   // R3
   angle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> angle_o == $past(angle_o) + step_o);

   // R7
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid && !err_small |=> !locked_o);

   // R7
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(smp_valid) && $past(err_small));

endmodule

// File: tb/quad_delay_pll_test.sv
module quad_delay_pll_test;

   localparam int       NOM   = 21474836;
   localparam int       SMIN  = 17179869;
   localparam int       SMAX  = 25769803;
   localparam int       LLEN  = 400;
   localparam longint   TURN  = 64'd4294967296;
   localparam real      PI    = 3.14159265358979;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_in = '0;
   logic [31:0]        angle_o, step_o;
   logic signed [17:0] vd_o;
   logic               locked_o;

   int checks = 0;
   int errors = 0;
   longint avg_step;
   bit     range_ok;

   always #5 clk = ~clk;

   quad_delay_pll uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
      .angle_o(angle_o), .step_o(step_o), .vd_o(vd_o), .locked_o(locked_o)
   );

   function automatic longint hz2step(input real f);
      return longint'(f / 10000.0 * real'(TURN));
   endfunction

   function automatic longint tab_entry(input int i);
      return longint'(32767.0 * $sin((real'(i) + 0.5) * PI / 2048.0));
   endfunction

   function automatic longint trig_sin(input logic [31:0] a);
      logic [1:0] q;
      int         idx;
      longint     m;
      q   = a[31:30];
      idx = int'(a[29:20]);
      m   = q[0] ? tab_entry(1023 - idx) : tab_entry(idx);
      return q[1] ? -m : m;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_valid = 1'b0;
      smp_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(input int v);
      @(negedge clk);
      smp_in = 16'(v);
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_tone(input real f, input real amp, input real ph, input int nsamp);
      longint sum = 0;
      range_ok = 1'b1;
      for (int n = 0; n < nsamp; n++) begin
         real x;
         x = amp * $sin(2.0 * PI * f * real'(n) / 10000.0 + ph);
         push(int'(x));
         if (step_o < 32'(SMIN) || step_o > 32'(SMAX)) range_ok = 1'b0;
         if (n >= nsamp - 1000) sum += longint'(step_o);
      end
      avg_step = sum / 1000;
   endtask

   task automatic tone_track(input real f, input real amp, input real ph, input string req);
      longint exp;
      do_reset();
      run_tone(f, amp, ph, 3000);
      exp = hz2step(f);
      check((avg_step - exp) <= 128849 && (exp - avg_step) <= 128849, req,
            "average step tracks tone", avg_step, exp);
      check(range_ok, "R6", "step stays in range during tone", longint'(range_ok), 1);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] exp_ang;
      logic [31:0] h_ang, h_step;
      logic signed [17:0] h_vd;
      logic        h_lock;
      longint      expv;
      void'($urandom(32'd20240611));

      // R1 reset state
      do_reset();
      check(angle_o == 0, "R1", "angle after reset", angle_o, 0);
      check(step_o == 32'(NOM), "R1", "step after reset", step_o, NOM);
      check(vd_o == 0, "R1", "vd after reset", vd_o, 0);
      check(!locked_o, "R1", "lock after reset", locked_o, 0);

      // R3 and R7: zero input ramps angle at nominal step, lock after LLEN samples
      exp_ang = '0;
      for (int n = 1; n <= LLEN; n++) begin
         push(0);
         exp_ang = exp_ang + 32'(NOM);
         check(angle_o == exp_ang, "R3", "angle ramp at zero input", angle_o, exp_ang);
         check(step_o == 32'(NOM), "R3", "step at zero input", step_o, NOM);
         if (n == LLEN - 1) check(!locked_o, "R7", "lock one sample early", locked_o, 0);
      end
      check(locked_o, "R7", "lock after full run", locked_o, 1);

      // R2 no strobe: outputs hold
      h_ang = angle_o; h_step = step_o; h_vd = vd_o; h_lock = locked_o;
      smp_in = 16'sd12345;
      repeat (8) @(negedge clk);
      check(angle_o == h_ang && step_o == h_step && vd_o == h_vd && locked_o == h_lock,
            "R2", "outputs hold without strobe", angle_o, h_ang);

      // R8 and R7: single large sample at known angle
      expv = (longint'(20000) * trig_sin(angle_o)) >>> 15;
      push(20000);
      check(longint'(vd_o) == expv, "R8", "direct component of one sample", vd_o, expv);
      check(!locked_o, "R7", "lock drops on large error", locked_o, 0);

      // R1 reset clears lag line and integral
      for (int n = 0; n < 10; n++) push(0);
      do_reset();
      begin
         bit ok = 1'b1;
         for (int n = 0; n < 60; n++) begin
            push(0);
            if (step_o != 32'(NOM)) ok = 1'b0;
         end
         check(ok, "R1", "zero input after reset keeps nominal step", step_o, NOM);
      end

      // R4 nominal tone
      do_reset();
      run_tone(50.0, 16000.0, 0.3, 3000);
      check((avg_step - NOM) <= 42950 && (NOM - avg_step) <= 42950, "R4",
            "average step at 50 Hz", avg_step, NOM);
      check(vd_o >= 18'sd15680 && vd_o <= 18'sd16320, "R4", "vd amplitude at 50 Hz", vd_o, 16000);
      check(locked_o, "R4", "locked at 50 Hz", locked_o, 1);

      // R5 directed off-nominal tones
      tone_track(55.0, 16000.0, 1.0, "R5");
      tone_track(45.0, 12000.0, 2.0, "R5");

      // R5 constrained random tones
      for (int t = 0; t < 3; t++) begin
         real f, a, p;
         f = 46.0 + real'($urandom % 800) / 100.0;
         a = 8000.0 + real'($urandom % 12000);
         p = real'($urandom % 6283) / 1000.0;
         tone_track(f, a, p, "R5");
      end

      // R6 out-of-range tones stay clamped
      do_reset();
      run_tone(70.0, 16000.0, 0.0, 3000);
      check(range_ok, "R6", "step clamp with 70 Hz input", longint'(range_ok), 1);
      do_reset();
      run_tone(30.0, 16000.0, 0.0, 3000);
      check(range_ok, "R6", "step clamp with 30 Hz input", longint'(range_ok), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule